// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block decides whether a two-byte relative branch instruction is taken and produces the program counter that follows it. A sequencer presents the branch opcode byte, the signed 8-bit displacement, the address where the opcode sits and the four arithmetic flags (negative, zero, overflow, carry), then pulses `start`. The block registers a taken indication and the next program counter on that same edge.

The opcode space 0x20 to 0x2F is grouped in pairs. Each even opcode tests a condition and the odd opcode next to it tests the inverse. Some conditions look at single flags. Others compare unsigned magnitudes through C and Z, and others compare signed magnitudes through N, V and Z. The target is measured from the byte after the two-byte branch, and all address arithmetic wraps at 16 bits.

Every branch takes a fixed four cycles whether or not it is taken. The block models this with a small timer. `busy` is high for the first three cycles and `done` is high for exactly one cycle, the fourth. Any `start` that arrives while `busy` is high is ignored.

Top module: `branch_resolve_unit`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `taken` are 0 and `next_pc` is 0x0000.
- R2: When a branch is taken, `next_pc` equals `op_addr + 2 + sign_extend(offset)`, modulo 2^16. Offset 0x80 means -128 and 0x7F means +127.
- R3: When a branch is not taken, `next_pc` equals `op_addr + 2`, modulo 2^16.
- R4: Opcode 0x20 is always taken and opcode 0x21 is never taken, whatever the flags.
- R5: Single-flag tests: 0x24 is taken when C=0 and 0x25 when C=1. 0x26 is taken when Z=0 and 0x27 when Z=1. 0x28 is taken when V=0 and 0x29 when V=1. 0x2A is taken when N=0 and 0x2B when N=1.
- R6: Unsigned magnitude tests: 0x22 is taken when (C or Z)=0, and 0x23 is taken when (C or Z)=1.
- R7: Signed tests: 0x2C is taken when (N xor V)=0, and 0x2D is taken when (N xor V)=1.
- R8: Signed tests that include zero: 0x2E is taken when (Z or (N xor V))=0, and 0x2F is taken when that expression is 1.
- R9: `taken` and `next_pc` are valid in the first cycle after the accepting edge. `busy` is high for cycles 1 to 3. `done` is high only in cycle 4, and `busy` is low in that cycle.
- R10: A `start` that arrives while `busy` is high does not change `taken`, `next_pc` or the timer sequence.
- R11: Any opcode whose upper nibble is not 0x2 is treated as not taken, so `next_pc` becomes `op_addr + 2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to resolve a branch; accepted only when `busy` is low |
| opcode | input | 8 | Branch opcode byte |
| offset | input | 8 | Signed displacement in two's complement |
| op_addr | input | 16 | Address of the branch opcode |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| busy | output | 1 | High during cycles 1 to 3 of a branch |
| done | output | 1 | One-cycle pulse in cycle 4 |
| taken | output | 1 | Registered branch decision |
| next_pc | output | 16 | Registered next program counter |

## Verification
The assertions assume that `opcode`, `offset`, `op_addr` and the flags are stable in the cycle in which `start` is sampled high. They also assume that the reset is held for at least one edge before any request. The bench drives every input on the falling edge and holds it across the accepting edge. It releases `start` only after the rising edge and never raises `start` during reset. This keeps the stimulus within those assumptions.

// File: rtl/bru_pkg.sv
package bru_pkg;

    parameter int unsigned ADDR_W    = 16;
    parameter int unsigned OFF_W     = 8;
    parameter int unsigned CYC_COUNT = 4;
    localparam logic [3:0] BR_GROUP  = 4'h2;

    // Condition order matches the low opcode nibble: even tests, odd inverts.
    typedef enum logic [3:0] {
        CND_ALWAYS = 4'h0, CND_NEVER = 4'h1,
        CND_HI     = 4'h2, CND_LS    = 4'h3,
        CND_CC     = 4'h4, CND_CS    = 4'h5,
        CND_NE     = 4'h6, CND_EQ    = 4'h7,
        CND_VC     = 4'h8, CND_VS    = 4'h9,
        CND_PL     = 4'hA, CND_MI    = 4'hB,
        CND_GE     = 4'hC, CND_LT    = 4'hD,
        CND_GT     = 4'hE, CND_LE    = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] pc;
    } branch_res_t;

    function automatic cond_e decode_cond(input logic [7:0] op);
        if (op[7:4] == BR_GROUP) decode_cond = cond_e'(op[3:0]);
        else                     decode_cond = CND_NEVER;
    endfunction

    function automatic logic test_cond(input cond_e cnd, input flags_t f);
        logic base;
        case (cond_e'({cnd[3:1], 1'b0}))
            CND_ALWAYS: base = 1'b1;
            CND_HI:     base = ~(f.c | f.z);
            CND_CC:     base = ~f.c;
            CND_NE:     base = ~f.z;
            CND_VC:     base = ~f.v;
            CND_PL:     base = ~f.n;
            CND_GE:     base = ~(f.n ^ f.v);
            CND_GT:     base = ~(f.z | (f.n ^ f.v));
            default:    base = 1'b0;
        endcase
        test_cond = base ^ cnd[0];
    endfunction

endpackage

// File: rtl/bru_cond_eval.sv
module bru_cond_eval
    import bru_pkg::*;
(
    input  logic [7:0] opcode,
    input  flags_t     flags,
    output logic       taken
);
    cond_e cnd;

    always_comb begin
        cnd   = decode_cond(opcode);
        taken = test_cond(cnd, flags);
    end

    always_comb begin
        if (opcode == 8'h21) begin
            a_never_r4: assert (!taken);
        end
    end
endmodule

// File: rtl/bru_target_calc.sv
module bru_target_calc
    import bru_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned OW = OFF_W
) (
    input  logic [AW-1:0] op_addr,
    input  logic [OW-1:0] offset,
    input  logic          taken,
    output logic [AW-1:0] next_pc
);
    localparam int unsigned EXT_W = AW - OW;
    localparam logic [AW-1:0] INSTR_LEN = AW'(2);

    logic [AW-1:0] fall_pc;
    logic [AW-1:0] disp;

    always_comb begin
        fall_pc = op_addr + INSTR_LEN;
        disp    = {{EXT_W{offset[OW-1]}}, offset};
        next_pc = taken ? (fall_pc + disp) : fall_pc;
    end
endmodule

// File: rtl/bru_cycle_timer.sv
module bru_cycle_timer
    import bru_pkg::*;
#(
    parameter int unsigned CYCLES = CYC_COUNT
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 2);

    logic [CNT_W-1:0] cnt;

    assign accept = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [7:0]  offset,
    input  logic [15:0] op_addr,
    input  logic        flag_n,
    input  logic        flag_z,
    input  logic        flag_v,
    input  logic        flag_c,
    output logic        busy,
    output logic        done,
    output logic        taken,
    output logic [15:0] next_pc
);
    flags_t        flags;
    branch_res_t   res_d;
    branch_res_t   res_q;
    logic          accept;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    bru_cond_eval u_cond (
        .opcode (opcode),
        .flags  (flags),
        .taken  (res_d.taken)
    );

    bru_target_calc #(.AW(ADDR_W), .OW(OFF_W)) u_target (
        .op_addr (op_addr),
        .offset  (offset),
        .taken   (res_d.taken),
        .next_pc (res_d.pc)
    );

    bru_cycle_timer #(.CYCLES(CYC_COUNT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (rst)         res_q <= '0;
        else if (accept) res_q <= res_d;
    end

    assign taken   = res_q.taken;
    assign next_pc = res_q.pc;

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_follows_busy_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
    p_hold_while_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(next_pc) && $stable(taken)));
    p_always_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode == 8'h20) |=> taken);
    p_never_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && opcode == 8'h21) |=> !taken);
    p_fallthrough_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (taken || next_pc == $past(op_addr) + 16'd2));
endmodule

// File: tb/branch_resolve_unit_tb.sv
module branch_resolve_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  opcode, offset;
    logic [15:0] op_addr;
    logic        fn, fz, fv, fc;
    logic        busy, done, taken;
    logic [15:0] next_pc;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    branch_resolve_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .offset(offset),
        .op_addr(op_addr), .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc),
        .busy(busy), .done(done), .taken(taken), .next_pc(next_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_taken(input logic [7:0] op, input logic [3:0] f);
        logic n, z, v, c;
        {n, z, v, c} = f;
        if (op[7:4] != 4'h2) return 1'b0;
        case (op[3:0])
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return (c == 0) && (z == 0);
            4'h3: return (c == 1) || (z == 1);
            4'h4: return c == 0;
            4'h5: return c == 1;
            4'h6: return z == 0;
            4'h7: return z == 1;
            4'h8: return v == 0;
            4'h9: return v == 1;
            4'hA: return n == 0;
            4'hB: return n == 1;
            4'hC: return n == v;
            4'hD: return n != v;
            4'hE: return (z == 0) && (n == v);
            default: return (z == 1) || (n != v);
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] op);
        if (op[7:4] != 4'h2) return "R11";
        case (op[3:0])
            4'h0, 4'h1: return "R4";
            4'h2, 4'h3: return "R6";
            4'hC, 4'hD: return "R7";
            4'hE, 4'hF: return "R8";
            default:    return "R5";
        endcase
    endfunction

    task automatic run_one(input logic [7:0] op, input logic [3:0] f,
                           input logic [7:0] off, input logic [15:0] addr,
                           input bit chk_timing);
        logic        exp_t;
        logic [15:0] exp_pc;
        int          disp;
        exp_t = model_taken(op, f);
        disp  = off[7] ? int'(off) - 256 : int'(off);
        exp_pc = exp_t ? 16'(int'(addr) + 2 + disp) : 16'(int'(addr) + 2);
        @(negedge clk);
        opcode = op; offset = off; op_addr = addr; {fn, fz, fv, fc} = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req_of(op), {31'd0, taken}, {31'd0, exp_t});
        check(exp_t ? "R2" : "R3", {16'd0, next_pc}, {16'd0, exp_pc});
        if (chk_timing) begin
            check("R9 busy c1", {31'd0, busy}, 32'd1);
            check("R9 done c1", {31'd0, done}, 32'd0);
            // out-of-window request while busy must be ignored
            opcode = 8'h20; offset = 8'h40; op_addr = ~addr; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R9 busy c2", {31'd0, busy}, 32'd1);
            check("R10 pc", {16'd0, next_pc}, {16'd0, exp_pc});
            check("R10 taken", {31'd0, taken}, {31'd0, exp_t});
            @(negedge clk);
            check("R9 busy c3", {31'd0, busy}, 32'd1);
            check("R9 done c3", {31'd0, done}, 32'd0);
            @(negedge clk);
            check("R9 done c4", {31'd0, done}, 32'd1);
            check("R9 busy c4", {31'd0, busy}, 32'd0);
            @(negedge clk);
            check("R9 done c5", {31'd0, done}, 32'd0);
        end else begin
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        int k;
        logic [7:0]  offs  [8] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'hFE, 8'h40, 8'hC3};
        logic [15:0] addrs [8] = '{16'h0000, 16'hFFFF, 16'hFFFE, 16'h8000,
                                   16'h7FFF, 16'h1234, 16'h00FF, 16'hFF80};
        rst = 1'b1; start = 1'b0; opcode = '0; offset = '0; op_addr = '0;
        {fn, fz, fv, fc} = 4'h0;
        repeat (3) @(negedge clk);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 taken", {31'd0, taken}, 32'd0);
        check("R1 pc", {16'd0, next_pc}, 32'd0);
        rst = 1'b0;

        k = 0;
        for (int op = 8'h20; op <= 8'h2F; op++) begin
            for (int f = 0; f < 16; f++) begin
                run_one(8'(op), 4'(f), offs[k % 8], addrs[(k / 8) % 8], (k % 37) == 0);
                k++;
            end
        end
        // wrap and reach boundaries on the always-taken opcode
        run_one(8'h20, 4'h0, 8'h7F, 16'hFFFF, 1'b1);
        run_one(8'h20, 4'h0, 8'h80, 16'h0000, 1'b0);
        run_one(8'h21, 4'hF, 8'h80, 16'hFFFE, 1'b0);
        // opcodes outside the branch group
        run_one(8'h30, 4'h0, 8'h10, 16'h1000, 1'b0);
        run_one(8'hA0, 4'h5, 8'h10, 16'hFFFF, 1'b0);
        run_one(8'h1F, 4'hF, 8'h80, 16'h2000, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule